// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block drives one serial output line with asynchronous character frames. A host loads a character into a holding register with a write strobe. The block moves the character into a shift register and sends it one bit per bit-rate tick: a low start bit, the data bits least significant first, an optional ninth bit, and a high stop bit. The ticks come from an external rate generator as a one-cycle enable.

When the transmit enable rises, the block first sends one frame's length of idle 1s, so a receiver can lock onto the line. While the break control is held and the transmitter is enabled, it sends frame-length groups of 0s back to back. Once break is released, it sends a single closing 1 bit before any later character.

Two flags report progress. The holding-register-empty flag shows that the character has been taken into the shift register. The done flag shows that the line has gone idle after its last group.

Top module: `serial_tx_engine`

## Requirements
- R1: While reset is held, txOut is 1, regEmpty is 1 and txDone is 1. The enable and break controls count as cleared, so a txEnable held high through reset gives a rising edge after reset.
- R2: One clock after txEnable goes from 0 to 1, a preamble becomes pending. At the next tick it goes out first as a group of 1s, 10 bits long when nineBit is 0 and 11 bits long when nineBit is 1. It takes priority over break and data.
- R3: A frame is sent as a 0 start bit, dataIn bits 0 to 7 in that order, ninthIn only when nineBit is 1, and a 1 stop bit. txOut changes only on the clock edge at which bitTick is 1, and each bit holds for one tick period.
- R4: A dataWrite clears regEmpty and txDone at the next clock edge. regEmpty returns to 1 on the tick edge at which that character's start bit appears on txOut.
- R5: txDone becomes 1 on the tick edge at which the last bit of a group ends with no further group to send. It stays 1 until the next write or group start. While txDone is 1, txOut is 1.
- R6: While sendBreak and the transmitter are both active, the block sends back-to-back groups of 0s of frame length (10 or 11 bits). Break outranks queued data but not the preamble.
- R7: After the last break group, once break is released, exactly one 1 bit goes out before any character frame.
- R8: If txEnable drops during a frame, that frame and the character already waiting in the holding register are both sent before the line idles. A character written while the transmitter is disabled and the line is idle is not sent until the transmitter is enabled again.
- R9: A waiting character starts on the tick right after the previous group's last bit, with no idle bit between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitTick | input | 1 | One-cycle bit-rate enable |
| txEnable | input | 1 | Transmitter enable |
| sendBreak | input | 1 | Continuous break request |
| nineBit | input | 1 | 1 selects 11-bit frames with a ninth data bit |
| dataWrite | input | 1 | Write strobe for the holding register |
| dataIn | input | 8 | Character to send |
| ninthIn | input | 1 | Ninth data bit, stored with dataIn |
| txOut | output | 1 | Serial line, idles at 1 |
| regEmpty | output | 1 | Holding register free |
| txDone | output | 1 | Line idle after the last group |

## Verification
Every change on txOut, and the setting of regEmpty and txDone, belongs to the clock edge at which bitTick is high. A write clears both flags at the first edge after the strobe. The preamble starts at the first tick after the cycle in which the enable rise was registered. The bench drives inputs on the falling edge and advances its reference model of the line at each rising edge. It then compares all three outputs at the next falling edge, so every result is checked in the cycle it is due, including the break, close and mid-frame disable sequences.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  // Strobes from the sequencing logic to the shifting datapath
  typedef struct packed {
    logic loadData;   // start a character frame from the holding register
    logic loadOnes;   // start an all-ones group (preamble or closing bit)
    logic loadBreak;  // start an all-zeros group of frame length
    logic shiftOut;   // advance the line by one bit
    logic longFrame;  // 9-bit character framing
  } txStrobes_t;
endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       txEnable,
  input  logic       sendBreak,
  input  logic       nineBit,
  input  logic       dataWrite,
  output txStrobes_t strobes,
  output logic       regEmpty,
  output logic       txDone
);
  localparam int SHORT_LEN = DATA_W + 2;
  localparam int LONG_LEN  = DATA_W + 3;
  localparam int CNT_W     = $clog2(LONG_LEN + 1);

  logic enReg, brkReg, preamblePend, afterBreak, busy;
  logic [CNT_W-1:0] bitsLeft, groupLast;
  logic lineFree, pick, wantPre, wantBrk, wantClose, wantData;
  logic selPre, selBrk, selClose, selData, anyLoad, finish;

  always_comb begin
    groupLast = nineBit ? CNT_W'(LONG_LEN - 1) : CNT_W'(SHORT_LEN - 1);
    lineFree  = !busy || (bitsLeft == '0);
    pick      = bitTick && lineFree;
    wantPre   = preamblePend && enReg;
    wantBrk   = enReg && brkReg;
    wantClose = afterBreak;
    wantData  = !regEmpty && (enReg || busy);
    selPre    = pick && wantPre;
    selBrk    = pick && !wantPre && wantBrk;
    selClose  = pick && !wantPre && !wantBrk && wantClose;
    selData   = pick && !wantPre && !wantBrk && !wantClose && wantData;
    anyLoad   = selPre || selBrk || selClose || selData;
    finish    = bitTick && busy && (bitsLeft == '0) && !anyLoad;
    strobes.loadData  = selData;
    strobes.loadOnes  = selPre || selClose;
    strobes.loadBreak = selBrk;
    strobes.shiftOut  = bitTick && busy && !anyLoad;
    strobes.longFrame = nineBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg        <= 1'b0;
      brkReg       <= 1'b0;
      preamblePend <= 1'b0;
      afterBreak   <= 1'b0;
      busy         <= 1'b0;
      bitsLeft     <= '0;
      regEmpty     <= 1'b1;
      txDone       <= 1'b1;
    end else begin
      enReg  <= txEnable;
      brkReg <= sendBreak;
      if (!enReg && txEnable)   preamblePend <= 1'b1;
      else if (!enReg || selPre) preamblePend <= 1'b0;
      if (selBrk)                 afterBreak <= 1'b1;
      else if (selClose || selPre) afterBreak <= 1'b0;
      if (anyLoad)     busy <= 1'b1;
      else if (finish) busy <= 1'b0;
      if (selClose)     bitsLeft <= '0;
      else if (anyLoad) bitsLeft <= groupLast;
      else if (bitTick && busy && bitsLeft != '0) bitsLeft <= bitsLeft - 1'b1;
      if (dataWrite)    regEmpty <= 1'b0;
      else if (selData) regEmpty <= 1'b1;
      if (dataWrite || anyLoad) txDone <= 1'b0;
      else if (finish)          txDone <= 1'b1;
    end
  end
endmodule

// File: rtl/sertx_datapath.sv
module sertx_datapath
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataWrite,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              ninthIn,
  input  txStrobes_t        strobes,
  output logic              txOut
);
  localparam int SHIFT_W = DATA_W + 3;

  logic [DATA_W-1:0]  dataReg;
  logic               ninthReg;
  logic [SHIFT_W-1:0] shiftReg, framePat, breakPat;

  always_comb begin
    framePat = {1'b1, (strobes.longFrame ? ninthReg : 1'b1), dataReg, 1'b0};
    for (int i = 0; i < SHIFT_W; i++)
      breakPat[i] = strobes.longFrame ? 1'b0 : (i == SHIFT_W - 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg  <= '0;
      ninthReg <= 1'b0;
      shiftReg <= '1;
    end else begin
      if (dataWrite) begin
        dataReg  <= dataIn;
        ninthReg <= ninthIn;
      end
      if (strobes.loadData)       shiftReg <= framePat;
      else if (strobes.loadBreak) shiftReg <= breakPat;
      else if (strobes.loadOnes)  shiftReg <= '1;
      else if (strobes.shiftOut)  shiftReg <= {1'b1, shiftReg[SHIFT_W-1:1]};
    end
  end

  assign txOut = shiftReg[0];
endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              txEnable,
  input  logic              sendBreak,
  input  logic              nineBit,
  input  logic              dataWrite,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              ninthIn,
  output logic              txOut,
  output logic              regEmpty,
  output logic              txDone
);
  txStrobes_t strobes;

  sertx_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .txEnable(txEnable),
    .sendBreak(sendBreak), .nineBit(nineBit), .dataWrite(dataWrite),
    .strobes(strobes), .regEmpty(regEmpty), .txDone(txDone)
  );

  sertx_datapath #(.DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .dataWrite(dataWrite), .dataIn(dataIn),
    .ninthIn(ninthIn), .strobes(strobes), .txOut(txOut)
  );
endmodule

// File: rtl/serial_tx_engine_chk.sv
module serial_tx_engine_chk (
  input logic clk,
  input logic rstN,
  input logic bitTick,
  input logic dataWrite,
  input logic txOut,
  input logic regEmpty,
  input logic txDone
);
  // R3: the line moves only on tick edges
  assert_line_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> $stable(txOut));
  // R4: a write clears both flags at the next edge
  assert_write_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    dataWrite |=> (!regEmpty && !txDone));
  // R4: the holding register frees up only on a tick edge
  assert_empty_on_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!bitTick && !regEmpty) |=> !regEmpty);
  // R5: a finished line is idle high
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> txOut);
  // R5: done rises only on a tick edge
  assert_done_on_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!bitTick && !txDone) |=> !txDone);
endmodule

bind serial_tx_engine serial_tx_engine_chk uChk (
  .clk(clk), .rstN(rstN), .bitTick(bitTick), .dataWrite(dataWrite),
  .txOut(txOut), .regEmpty(regEmpty), .txDone(txDone)
);

// File: tb/tb_serial_tx_engine.sv
module tb_serial_tx_engine;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0;
  logic txEnable = 1'b0, sendBreak = 1'b0, nineBit = 1'b0;
  logic dataWrite = 1'b0, ninthIn = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic txOut, regEmpty, txDone;

  int nChecks = 0;
  int nFails = 0;
  string curReq = "R1";
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  serial_tx_engine dut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .txEnable(txEnable),
    .sendBreak(sendBreak), .nineBit(nineBit), .dataWrite(dataWrite),
    .dataIn(dataIn), .ninthIn(ninthIn), .txOut(txOut),
    .regEmpty(regEmpty), .txDone(txDone)
  );

  // tick every fourth cycle
  int tickPhase = 0;
  always @(negedge clk) begin
    tickPhase = (tickPhase + 1) % 4;
    bitTick = (tickPhase == 3);
  end

  // behavioural reference model
  bit   lineQ[$];
  bit   mEn = 0, mBrk = 0, mPend = 0, mAfter = 0, mEmpty = 1, mDone = 1, mOut = 1;
  logic [7:0] mData = 0;
  bit   mNinth = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      lineQ.delete();
      mEn = 0; mBrk = 0; mPend = 0; mAfter = 0; mEmpty = 1; mDone = 1;
    end else begin
      bit preTaken;
      preTaken = 0;
      if (bitTick) begin
        bit wasBusy, free, loaded;
        int len;
        wasBusy = lineQ.size() > 0;
        free = lineQ.size() <= 1;
        loaded = 0;
        len = nineBit ? 11 : 10;
        if (wasBusy) void'(lineQ.pop_front());
        if (free) begin
          if (mPend && mEn) begin
            repeat (len) lineQ.push_back(1);
            preTaken = 1; mAfter = 0; loaded = 1;
          end else if (mEn && mBrk) begin
            repeat (len) lineQ.push_back(0);
            mAfter = 1; loaded = 1;
          end else if (mAfter) begin
            lineQ.push_back(1);
            mAfter = 0; loaded = 1;
          end else if (!mEmpty && (mEn || wasBusy)) begin
            lineQ.push_back(0);
            for (int i = 0; i < 8; i++) lineQ.push_back(mData[i]);
            if (nineBit) lineQ.push_back(mNinth);
            lineQ.push_back(1);
            mEmpty = 1; loaded = 1;
          end
          if (loaded) mDone = 0;
          else if (wasBusy) mDone = 1;
        end
      end
      if (dataWrite) begin
        mData = dataIn; mNinth = ninthIn; mEmpty = 0; mDone = 0;
      end
      if (!mEn && txEnable) mPend = 1;
      else if (!mEn || preTaken) mPend = 0;
      mEn = txEnable;
      mBrk = sendBreak;
    end
    mOut = (lineQ.size() > 0) ? lineQ[0] : 1'b1;
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare against the model on every cycle
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(curReq, "txOut", txOut, mOut);
      check(curReq, "regEmpty", regEmpty, mEmpty);
      check(curReq, "txDone", txDone, mDone);
    end
  end

  task automatic waitTicks(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic writeChar(input logic [7:0] d, input logic n9);
    @(negedge clk);
    dataIn = d; ninthIn = n9; dataWrite = 1'b1;
    @(negedge clk);
    dataWrite = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nFails++;
      $display("FAIL watchdog expired at %0t", $time);
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state, with enable and break pushed high during reset
    txEnable = 1'b1; sendBreak = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "txOut in reset", txOut, 1'b1);
    check("R1", "regEmpty in reset", regEmpty, 1'b1);
    check("R1", "txDone in reset", txDone, 1'b1);
    sendBreak = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    // R2: enable held through reset rises afterwards, 10-bit preamble
    curReq = "R2";
    waitTicks(14);
    // R3: frame of 0xA5, then R9 back-to-back pair
    curReq = "R3";
    writeChar(8'hA5, 1'b0);
    waitTicks(3);
    curReq = "R9";
    writeChar(8'h3C, 1'b0);
    waitTicks(4);
    writeChar(8'h81, 1'b0);
    curReq = "R5";
    waitTicks(34);
    // R2 with 11-bit preamble, then a 9-bit frame
    curReq = "R2";
    txEnable = 1'b0; nineBit = 1'b1;
    waitTicks(2);
    txEnable = 1'b1;
    waitTicks(2);
    curReq = "R3";
    writeChar(8'h5A, 1'b1);
    waitTicks(28);
    // R6: break with a character waiting, R7: closing bit afterwards
    curReq = "R6";
    nineBit = 1'b0;
    sendBreak = 1'b1;
    waitTicks(3);
    writeChar(8'hF0, 1'b0);
    waitTicks(26);
    curReq = "R7";
    sendBreak = 1'b0;
    waitTicks(30);
    // R8: drop enable mid-frame with a character waiting
    curReq = "R8";
    writeChar(8'h11, 1'b0);
    waitTicks(3);
    writeChar(8'h22, 1'b0);
    waitTicks(2);
    txEnable = 1'b0;
    waitTicks(30);
    // R8: write while disabled and idle is held back
    writeChar(8'h99, 1'b0);
    waitTicks(15);
    check("R8", "txOut held idle", txOut, 1'b1);
    check("R8", "regEmpty held full", regEmpty, 1'b0);
    txEnable = 1'b1;
    waitTicks(30);
    check("R5", "txDone after drain", txDone, 1'b1);
    check("R4", "regEmpty after drain", regEmpty, 1'b1);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule